// File: doc/BRIEF.md
# MII Ethernet Frame Transmitter

The block sits on the MAC side of a 4-bit media-independent transmit interface. It accepts payload bytes from a valid/ready source and puts a complete Ethernet frame on the nibble bus, one nibble per clock. The frame is built in wire order: preamble, start delimiter, destination and source addresses, an optional IEEE 802.1Q tag, type/length, payload, zero padding up to the minimum size, and the 32-bit frame check sequence. Every byte leaves low nibble first.

A frame starts when the source raises `s_valid` while the line is idle and the inter-frame gap has elapsed. The header inputs are captured in that cycle. The source marks the final payload byte with `s_last`. If the source withdraws `s_valid` when a payload byte is due, the frame is aborted: one nibble is sent with the error line raised, and the enable line then falls. Below the MAC the frame is opaque. Addresses, payload and check sequence are all just nibbles to the PHY.

Top module: `mii_frame_tx`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `mii_tx_en`, `mii_tx_er`, `mii_txd` and `s_ready` are all 0.
- R2: A frame opens with 15 nibbles of 0x5 followed by one nibble of 0xD, with `mii_tx_en` high. `mii_tx_en` rises on the clock edge after the one where `s_valid` is seen while the line is idle and the gap has elapsed.
- R3: The destination address follows, then the source address, then type/length. Each address goes out most significant byte first (bits 47:40 first), type/length goes out bits 15:8 first, and each byte is sent bits 3:0 first.
- R4: When `tag_en` is 1 at frame start, the bytes 0x81, 0x00, {`tag_prio`, `tag_vid[11:8]`} and `tag_vid[7:0]` are inserted between the source address and type/length.
- R5: Payload bytes are sent in the order accepted, low nibble first. A byte is accepted on a clock edge where `s_valid` and `s_ready` are both high, and `s_ready` is high for at most one cycle per byte.
- R6: If the bytes from the destination address through the payload number fewer than 60, zero bytes are appended until there are exactly 60.
- R7: Eight check-sequence nibbles follow. They are bits [3:0], [7:4], …, [31:28] of the complement of a reflected CRC-32 (polynomial 0x04C11DB7, register starting at all ones), computed over the bytes from the destination address through the pad.
- R8: `mii_tx_en` falls on the clock after the last check-sequence nibble. `mii_tx_er` is 0 throughout a completed frame, and `mii_txd` and `mii_tx_er` are 0 whenever `mii_tx_en` is 0.
- R9: If `s_valid` is low when a payload byte is due, the next nibble has `mii_txd`=0 and `mii_tx_er`=1 with `mii_tx_en` high, and `mii_tx_en` falls on the following clock. No pad and no check sequence are sent.
- R10: At least 24 cycles with `mii_tx_en` low separate two frames. When the next frame is already waiting, the gap is exactly 24 cycles.
- R11: The header inputs are sampled only at frame start. Changing them while the frame is being sent has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Source has a payload byte |
| s_ready | output | 1 | Block takes the byte on this edge |
| s_data | input | 8 | Payload byte |
| s_last | input | 1 | Byte is the final payload byte of the frame |
| dst_mac | input | 48 | Destination address |
| src_mac | input | 48 | Source address |
| len_type | input | 16 | Type/length field |
| tag_en | input | 1 | Insert the VLAN tag |
| tag_prio | input | 4 | Tag priority field |
| tag_vid | input | 12 | Tag VLAN identifier |
| mii_txd | output | 4 | Transmit nibble |
| mii_tx_en | output | 1 | Transmit enable |
| mii_tx_er | output | 1 | Transmit error, raised to corrupt an aborted frame |

## Verification
The assertions assume that the source keeps `s_valid`, `s_data` and `s_last` steady from the moment it raises `s_valid` until the byte is taken. A withdrawn `s_valid` is treated only as a deliberate underrun. The assertions also assume that the header inputs hold their values on the cycle a frame starts. The stimulus changes payload inputs only just after a clock edge where a byte was accepted, and changes header fields only before a frame starts or, in the one frame that tests that header changes are ignored, well after start. The stimulus withdraws `s_valid` mid-payload in exactly one frame, to provoke the abort path. Frames are queued back to back so that the minimum gap is exercised as well as the slack case.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_PAY,
        ST_PAD,
        ST_FCS
    } tx_state_e;

    // Advance a reflected CRC-32 register by one nibble, bit 0 first.
    function automatic logic [31:0] crc32_step4(input logic [31:0] c, input logic [3:0] n);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 4; i++) begin
            if (r[0] ^ n[i]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/mii_tx_hdr.sv
module mii_tx_hdr #(
    parameter int          IDX_W = 6,
    parameter logic [15:0] TPID  = 16'h8100
) (
    input  logic [47:0]      dst,
    input  logic [47:0]      src,
    input  logic [15:0]      lt,
    input  logic             vt,
    input  logic [3:0]       pr,
    input  logic [11:0]      vid,
    input  logic [IDX_W-1:0] idx,
    output logic [3:0]       nib
);
    localparam int HB   = 18;
    localparam int HV_W = HB * 8;

    logic [HV_W-1:0] hv;
    logic [7:0]      b;
    int              bi;

    // Header laid out first-byte-on-wire at the top of the vector.
    always_comb begin
        hv  = vt ? {dst, src, TPID, pr, vid, lt} : {dst, src, lt, 32'h0};
        bi  = int'(idx >> 1);
        b   = hv[HV_W-1-8*bi -: 8];
        nib = idx[0] ? b[7:4] : b[3:0];
    end
endmodule

// File: rtl/mii_tx_crc.sv
module mii_tx_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [3:0]  nib,
    output logic [31:0] crc_q
);
    import mii_tx_pkg::*;

    logic [31:0] crc_d;

    always_comb begin
        crc_d = crc_q;
        if (clr)     crc_d = '1;
        else if (en) crc_d = crc32_step4(crc_q, nib);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end
endmodule

// File: rtl/mii_tx_gap.sv
module mii_tx_gap #(
    parameter int IFG = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_en,
    output logic ok
);
    localparam int GW = (IFG > 2) ? $clog2(IFG) : 1;
    localparam logic [GW-1:0] TOP = GW'(IFG - 1);

    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        ok = (cnt_q == TOP);
        if (line_en) cnt_d = '0;
        else if (ok) cnt_d = cnt_q;
        else         cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= TOP;
        else        cnt_q <= cnt_d;
    end

    // R10: a frame may only begin after the full count of idle cycles
    assert_ifg_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en && !$past(line_en)) |-> ($past(cnt_q) == TOP));
endmodule

// File: rtl/mii_frame_tx.sv
module mii_frame_tx #(
    parameter int PRE_BYTES = 7,
    parameter int MIN_BYTES = 60,
    parameter int IFG       = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        s_valid,
    output logic        s_ready,
    input  logic [7:0]  s_data,
    input  logic        s_last,
    input  logic [47:0] dst_mac,
    input  logic [47:0] src_mac,
    input  logic [15:0] len_type,
    input  logic        tag_en,
    input  logic [3:0]  tag_prio,
    input  logic [11:0] tag_vid,
    output logic [3:0]  mii_txd,
    output logic        mii_tx_en,
    output logic        mii_tx_er
);
    import mii_tx_pkg::*;

    localparam int PRE_NIB     = 2 * (PRE_BYTES + 1);
    localparam int HDR_NIB     = 28;
    localparam int HDR_TAG_NIB = 36;
    localparam int CNT_MAX     = (PRE_NIB > HDR_TAG_NIB) ? PRE_NIB : HDR_TAG_NIB;
    localparam int CNT_W       = $clog2(CNT_MAX + 1);
    localparam int BC_W        = $clog2(MIN_BYTES + 1);
    localparam logic [BC_W-1:0] BC_MIN = BC_W'(MIN_BYTES);

    typedef struct packed {
        tx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [BC_W-1:0]  bc;
        logic             ph;
        logic [3:0]       hi;
        logic             last;
        logic [3:0]       txd;
        logic             en;
        logic             er;
        logic [47:0]      dst;
        logic [47:0]      src;
        logic [15:0]      lt;
        logic             vt;
        logic [3:0]       pr;
        logic [11:0]      vid;
    } tx_regs_t;

    tx_regs_t         r_d, r_q;
    logic [3:0]       hdr_nib;
    logic [31:0]      crc_q;
    logic [31:0]      fcs;
    logic             crc_clr, crc_en;
    logic             gap_ok;
    logic             ready_c;
    logic [BC_W-1:0]  bc_inc;
    logic [CNT_W-1:0] hdr_last;

    mii_tx_hdr #(.IDX_W(CNT_W)) u_hdr (
        .dst (r_q.dst),
        .src (r_q.src),
        .lt  (r_q.lt),
        .vt  (r_q.vt),
        .pr  (r_q.pr),
        .vid (r_q.vid),
        .idx (r_q.cnt),
        .nib (hdr_nib)
    );

    mii_tx_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .nib   (r_d.txd),
        .crc_q (crc_q)
    );

    mii_tx_gap #(.IFG(IFG)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_en (r_q.en),
        .ok      (gap_ok)
    );

    assign fcs = ~crc_q;

    always_comb begin
        r_d      = r_q;
        r_d.en   = 1'b0;
        r_d.er   = 1'b0;
        r_d.txd  = 4'h0;
        crc_clr  = 1'b0;
        crc_en   = 1'b0;
        ready_c  = 1'b0;
        bc_inc   = (r_q.bc == BC_MIN) ? r_q.bc : r_q.bc + 1'b1;
        hdr_last = r_q.vt ? CNT_W'(HDR_TAG_NIB - 1) : CNT_W'(HDR_NIB - 1);

        unique case (r_q.st)
            ST_IDLE: begin
                if (s_valid && gap_ok) begin
                    r_d.dst = dst_mac;
                    r_d.src = src_mac;
                    r_d.lt  = len_type;
                    r_d.vt  = tag_en;
                    r_d.pr  = tag_prio;
                    r_d.vid = tag_vid;
                    r_d.st  = ST_PRE;
                    r_d.cnt = CNT_W'(1);
                    r_d.bc  = '0;
                    r_d.ph  = 1'b0;
                    r_d.en  = 1'b1;
                    r_d.txd = 4'h5;
                    crc_clr = 1'b1;
                end
            end
            ST_PRE: begin
                r_d.en = 1'b1;
                if (r_q.cnt == CNT_W'(PRE_NIB - 1)) begin
                    r_d.txd = 4'hD;
                    r_d.st  = ST_HDR;
                    r_d.cnt = '0;
                end else begin
                    r_d.txd = 4'h5;
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_HDR: begin
                r_d.en  = 1'b1;
                r_d.txd = hdr_nib;
                crc_en  = 1'b1;
                if (r_q.cnt[0]) r_d.bc = bc_inc;
                if (r_q.cnt == hdr_last) begin
                    r_d.st  = ST_PAY;
                    r_d.ph  = 1'b0;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_PAY: begin
                r_d.en = 1'b1;
                if (!r_q.ph) begin
                    ready_c = 1'b1;
                    if (s_valid) begin
                        r_d.txd  = s_data[3:0];
                        r_d.hi   = s_data[7:4];
                        r_d.last = s_last;
                        r_d.ph   = 1'b1;
                        crc_en   = 1'b1;
                    end else begin
                        r_d.er = 1'b1;
                        r_d.st = ST_IDLE;
                    end
                end else begin
                    r_d.txd = r_q.hi;
                    r_d.bc  = bc_inc;
                    r_d.ph  = 1'b0;
                    r_d.cnt = '0;
                    crc_en  = 1'b1;
                    if (r_q.last) r_d.st = (bc_inc == BC_MIN) ? ST_FCS : ST_PAD;
                end
            end
            ST_PAD: begin
                r_d.en = 1'b1;
                crc_en = 1'b1;
                if (r_q.ph) begin
                    r_d.bc = bc_inc;
                    r_d.ph = 1'b0;
                    if (bc_inc == BC_MIN) begin
                        r_d.st  = ST_FCS;
                        r_d.cnt = '0;
                    end
                end else begin
                    r_d.ph = 1'b1;
                end
            end
            ST_FCS: begin
                r_d.en  = 1'b1;
                r_d.txd = fcs[{r_q.cnt[2:0], 2'b00} +: 4];
                if (r_q.cnt == CNT_W'(7)) r_d.st  = ST_IDLE;
                else                      r_d.cnt = r_q.cnt + 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign s_ready   = ready_c;
    assign mii_txd   = r_q.txd;
    assign mii_tx_en = r_q.en;
    assign mii_tx_er = r_q.er;

    // R9: the error line is only driven inside a frame
    assert_er_inside_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mii_tx_er |-> mii_tx_en);

    // R9: an aborted frame ends right after its error nibble
    assert_er_ends_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mii_tx_er |=> !mii_tx_en);

    // R5: bytes are taken only while a frame is on the line
    assert_ready_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> mii_tx_en);

    // R5: an accepted byte shows its low nibble on the next cycle
    assert_low_nibble_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> (mii_txd == $past(s_data[3:0])));

    // R8: the line is quiet between frames
    assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mii_tx_en |-> (mii_txd == 4'h0 && !mii_tx_er));
endmodule

// File: tb/mii_frame_tx_test.sv
module mii_frame_tx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [7:0]  s_data = 8'h0;
    logic        s_last = 1'b0;
    logic [47:0] dst_mac = '0;
    logic [47:0] src_mac = '0;
    logic [15:0] len_type = '0;
    logic        tag_en = 1'b0;
    logic [3:0]  tag_prio = '0;
    logic [11:0] tag_vid = '0;
    logic [3:0]  txd;
    logic        tx_en;
    logic        tx_er;

    always #10 clk = ~clk;

    mii_frame_tx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_ready   (s_ready),
        .s_data    (s_data),
        .s_last    (s_last),
        .dst_mac   (dst_mac),
        .src_mac   (src_mac),
        .len_type  (len_type),
        .tag_en    (tag_en),
        .tag_prio  (tag_prio),
        .tag_vid   (tag_vid),
        .mii_txd   (txd),
        .mii_tx_en (tx_en),
        .mii_tx_er (tx_er)
    );

    typedef struct {
        logic [3:0] n;
        logic       er;
        bit         last;
        string      req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   failures = 0;
    bit   done = 0;
    bit   expect_end = 0;
    string end_req = "R8";
    bit   prev_en = 0;
    bit   seen_frame = 0;
    int   low_cnt = 0;
    int   min_gap = 100000;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push_nib(input logic [3:0] n, input logic er, input bit last, input string req);
        exp_t e;
        e.n = n; e.er = er; e.last = last; e.req = req;
        q.push_back(e);
    endtask

    task automatic push_byte(input logic [7:0] b, input string req);
        push_nib(b[3:0], 1'b0, 1'b0, req);
        push_nib(b[7:4], 1'b0, 1'b0, req);
    endtask

    function automatic logic [31:0] crc_bytes(input logic [7:0] bs[$]);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        foreach (bs[k]) begin
            c = c ^ {24'h0, bs[k]};
            for (int j = 0; j < 8; j++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    // Monitor: pops the scoreboard on every active nibble
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !done) begin
            if (expect_end) begin
                chk(!tx_en, end_req, "tx_en after final nibble", tx_en, 0);
                expect_end = 0;
            end
            if (tx_en) begin
                if (q.size() == 0) begin
                    chk(0, "R8", "unexpected nibble", {tx_er, txd}, 0);
                end else begin
                    e = q.pop_front();
                    chk(txd == e.n && tx_er == e.er, e.req, "nibble {er,txd}",
                        {tx_er, txd}, {e.er, e.n});
                    if (e.last) begin
                        expect_end = 1;
                        end_req = e.er ? "R9" : "R8";
                    end
                end
            end else begin
                chk(txd == 4'h0 && tx_er == 1'b0, "R8", "idle line {er,txd}", {tx_er, txd}, 0);
            end
            if (tx_en && !prev_en) begin
                if (seen_frame) begin
                    chk(low_cnt >= 24, "R10", "inter-frame gap", low_cnt, 24);
                    if (low_cnt < min_gap) min_gap = low_cnt;
                end
                seen_frame = 1;
            end
            if (tx_en) low_cnt = 0;
            else       low_cnt++;
            prev_en = tx_en;
        end
    end

    task automatic send_byte(input logic [7:0] b, input logic l);
        s_data  = b;
        s_last  = l;
        s_valid = 1'b1;
        @(negedge clk);
        while (!s_ready) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (q.size() != 0 || tx_en) @(negedge clk);
    endtask

    task automatic send_frame(input logic [47:0] d, input logic [47:0] s, input logic [15:0] t,
                              input bit vt, input logic [3:0] pr, input logic [11:0] vid,
                              input int n, input logic [7:0] seed, input int abort_after,
                              input bit scramble);
        logic [7:0]  fb[$];
        logic [7:0]  p[$];
        logic [31:0] f;
        string       hreq;
        hreq = scramble ? "R11" : "R3";
        for (int i = 0; i < n; i++) p.push_back(seed + 8'(i * 13));
        for (int i = 0; i < 15; i++) push_nib(4'h5, 1'b0, 1'b0, "R2");
        push_nib(4'hD, 1'b0, 1'b0, "R2");
        for (int i = 5; i >= 0; i--) begin fb.push_back(d[8*i +: 8]); push_byte(d[8*i +: 8], hreq); end
        for (int i = 5; i >= 0; i--) begin fb.push_back(s[8*i +: 8]); push_byte(s[8*i +: 8], hreq); end
        if (vt) begin
            fb.push_back(8'h81);          push_byte(8'h81, "R4");
            fb.push_back(8'h00);          push_byte(8'h00, "R4");
            fb.push_back({pr, vid[11:8]}); push_byte({pr, vid[11:8]}, "R4");
            fb.push_back(vid[7:0]);       push_byte(vid[7:0], "R4");
        end
        fb.push_back(t[15:8]); push_byte(t[15:8], hreq);
        fb.push_back(t[7:0]);  push_byte(t[7:0], hreq);
        if (abort_after >= 0) begin
            for (int i = 0; i < abort_after; i++) push_byte(p[i], "R5");
            push_nib(4'h0, 1'b1, 1'b1, "R9");
        end else begin
            foreach (p[i]) begin fb.push_back(p[i]); push_byte(p[i], "R5"); end
            while (fb.size() < 60) begin fb.push_back(8'h00); push_byte(8'h00, "R6"); end
            f = crc_bytes(fb);
            for (int i = 0; i < 8; i++) push_nib(f[4*i +: 4], 1'b0, i == 7, "R7");
        end

        dst_mac = d; src_mac = s; len_type = t;
        tag_en = vt; tag_prio = pr; tag_vid = vid;
        if (scramble) begin
            fork
                begin
                    @(posedge tx_en);
                    repeat (20) @(negedge clk);
                    dst_mac = ~d; src_mac = ~s; len_type = ~t;
                    tag_en = 1'b1; tag_prio = 4'hF; tag_vid = 12'hABC;
                end
            join_none
        end
        if (abort_after >= 0) begin
            for (int i = 0; i < abort_after; i++) send_byte(p[i], 1'b0);
            s_valid = 1'b0;
            repeat (6) @(negedge clk);
        end else begin
            for (int i = 0; i < n; i++) send_byte(p[i], i == n - 1);
            s_valid = 1'b0;
            s_last  = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is held
        chk(tx_en == 0 && tx_er == 0, "R1", "en/er in reset", {tx_en, tx_er}, 0);
        chk(txd == 0 && s_ready == 0, "R1", "txd/ready in reset", {s_ready, txd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_en == 0 && tx_er == 0, "R1", "en/er after reset", {tx_en, tx_er}, 0);
        chk(txd == 0 && s_ready == 0, "R1", "txd/ready after reset", {s_ready, txd}, 0);

        // Short untagged frame padded, then a full 60-byte frame back to back
        send_frame(48'h0123_4567_89AB, 48'hA1B2_C3D4_E5F6, 16'h0800, 0, 4'h0, 12'h000, 10, 8'h11, -1, 0);
        send_frame(48'hFFFF_FFFF_FFFF, 48'h0200_0000_0001, 16'h002E, 0, 4'h0, 12'h000, 46, 8'h3C, -1, 0);
        // Tagged frames: padded and long
        send_frame(48'h1122_3344_5566, 48'h6655_4433_2211, 16'h86DD, 1, 4'hA, 12'h5C3, 3, 8'h70, -1, 0);
        send_frame(48'hDEAD_BEEF_0042, 48'h0042_BEEF_DEAD, 16'h0806, 1, 4'h3, 12'hFFF, 60, 8'hE1, -1, 0);
        // Underrun after five payload bytes
        send_frame(48'h0A0B_0C0D_0E0F, 48'hF0E0_D0C0_B0A0, 16'h1234, 0, 4'h0, 12'h000, 5, 8'h5A, 5, 0);
        // Header inputs disturbed during the frame
        wait_idle();
        send_frame(48'h0F1E_2D3C_4B5A, 48'h5A4B_3C2D_1E0F, 16'h0101, 0, 4'h0, 12'h000, 20, 8'h99, -1, 1);
        // Single-byte payload
        send_frame(48'h0000_0000_0001, 48'h0000_0000_0002, 16'h0042, 0, 4'h0, 12'h000, 1, 8'hC7, -1, 0);

        wait_idle();
        repeat (30) @(negedge clk);
        chk(q.size() == 0, "R8", "scoreboard drained", q.size(), 0);
        chk(min_gap == 24, "R10", "minimum gap back to back", min_gap, 24);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", q.size(), 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule